// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

One channel of an interval timer that sits behind a small word-indexed register port. The counter moves forward once per prescaled period of a slow counting clock, which reaches the block as a one-cycle enable pulse, `slow_tick`. The counter climbs from zero to the compare value, clears itself, and sets a sticky match flag. The flag can drive a level interrupt. The channel runs only while its own bit in a run vector is high. That vector is shared with sibling channels, and the parameter `CH_SEL` picks which bit belongs to this channel.

The same RTL builds two variants, chosen by `CNT_W`. The 16-bit variant keeps its match flag in control bit 7. The 32-bit variant keeps its match flag in bit 15 and adds a roll-over flag in bit 14. Software may rewrite the compare value while the counter is counting. A write to the counter is held back until two slow-clock pulses have passed, which models the crossing into the slow counting domain.

The register port has no handshake. A write completes on the clock edge where `reg_wr` is sampled, and read data is valid combinationally for the current `reg_addr`. No stream interface exists, so no back-pressure rules apply.

Top module: `cmt_channel`

## Requirements
- R1: After reset, the control register reads 0, the counter reads 0, the compare register reads all ones, and `irq` is low.
- R2: Registers are selected by word index: 0 is the control/status register, 1 is the counter and 2 is the compare value. A system bus maps these at a byte stride of 2 for 16-bit access or 4 for 32-bit access. Index 3 reads as 0.
- R3: The channel counts only while `run_bits[CH_SEL]` is 1. While it is 0 the counter holds its value, and the other bits of `run_bits` have no effect.
- R4: Control bits [1:0] select the prescale divisor as 8 << (2*sel), giving 8, 32, 128 or 512 slow ticks per count. The prescaler restarts whenever the run bit is low, so the first count after a start comes a full divisor after that start.
- R5: The counter steps up by one on each prescaled tick. On the tick where it equals the compare value it returns to 0, so one period is (compare+1) x divisor slow ticks.
- R6: A compare match sets a sticky match flag: bit 7 in the 16-bit variant and bit 15 in the 32-bit variant. The flag stays set across later matches.
- R7: Writing the control register with a flag bit at 0 clears that flag. Writing it with a 1 leaves the flag unchanged. A match in the same cycle as a clear wins.
- R8: In the 32-bit variant, when the counter rolls from all ones to 0 without matching, bit 14 is set. It is sticky and is cleared in the same way as the match flag.
- R9: `irq` is the match flag ANDed with the interrupt-enable bit, which is bit 6 in the 16-bit variant and bit 5 in the 32-bit variant. It is a level signal. Writing 0 to the control register drops it. Configuration 0x43 (16-bit) gives /512 with the interrupt on, and 0x1A4 (32-bit) gives /8 with the interrupt on.
- R10: A counter write takes effect on the second `slow_tick` after the write. Until then, reads return the old value.
- R11: The compare value may be rewritten while the counter runs. The next match is taken against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One pulse per cycle of the slow counting clock |
| run_bits | input | N_CH | Shared run vector; bit CH_SEL runs this channel |
| reg_addr | input | 2 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two instances side by side. The first is a 32-bit channel on run bit 0, which exposes the roll-over flag at bit 14, the /8 configuration, and roll-over from a preloaded counter near all ones. The second is a 16-bit channel on run bit 2, which brings in the bit-7 flag, the bit-6 enable and the /512 divisor. Because both instances listen to the same run vector, toggling either channel's bit also shows that the other channel ignores it.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    IDX_CSR = 2'd0,
    IDX_CNT = 2'd1,
    IDX_CMP = 2'd2,
    IDX_NONE = 2'd3
  } reg_idx_e;

  localparam int PRESC_W = 9;

  // prescale divisor for a select code: 8, 32, 128, 512
  function automatic logic [PRESC_W:0] presc_div(input logic [1:0] sel);
    return (PRESC_W+1)'(8) << (2 * sel);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow_tick,
  input  logic [1:0] sel,
  output logic       count_en
);
  logic [PRESC_W-1:0] phase_q;
  logic [PRESC_W:0]   last;

  always_comb last = presc_div(sel) - 1'b1;
  assign count_en = run && slow_tick && ({1'b0, phase_q} == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= '0;
    else if (!run)         phase_q <= '0;
    else if (count_en)     phase_q <= '0;
    else if (slow_tick)    phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_tick,
  input  logic         count_en,
  input  logic         wr_cnt,
  input  logic         wr_cmp,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp,
  output logic         apply,
  output logic         match_ev,
  output logic         wrap_ev
);
  logic         pend_q, stage_q;
  logic [W-1:0] pend_val_q;

  assign apply    = pend_q && stage_q && slow_tick && !wr_cnt;
  assign match_ev = count_en && !apply && (cnt == cmp);
  assign wrap_ev  = count_en && !apply && (cnt != cmp) && (&cnt);

  // pending counter write crossing into the slow domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      stage_q    <= 1'b0;
      pend_val_q <= '0;
    end else if (wr_cnt) begin
      pend_q     <= 1'b1;
      stage_q    <= 1'b0;
      pend_val_q <= wdata;
    end else if (pend_q && slow_tick) begin
      if (stage_q) begin
        pend_q  <= 1'b0;
        stage_q <= 1'b0;
      end else begin
        stage_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (apply)    cnt <= pend_val_q;
    else if (match_ev) cnt <= '0;
    else if (count_en) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp <= '1;
    else if (wr_cmp) cmp <= wdata;
  end
endmodule

// File: rtl/cmt_ctrl_reg.sv
module cmt_ctrl_reg #(
  parameter int FLAG_BIT = 15,
  parameter int IE_BIT   = 5,
  parameter bit HAS_WRAP = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        match_ev,
  input  logic        wrap_ev,
  output logic [15:0] csr_rd,
  output logic [1:0]  sel,
  output logic        flag,
  output logic        irq
);
  localparam int         WRAP_BIT  = 14;
  localparam logic [15:0] FLAG_MASK = (16'(1) << FLAG_BIT)
                                    | (HAS_WRAP ? (16'(1) << WRAP_BIT) : 16'h0);

  logic [15:0] ctl_q;
  logic        flag_q;
  logic        wrap_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= wdata & ~FLAG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (match_ev) flag_q <= 1'b1;
    else if (wr)       flag_q <= flag_q & wdata[FLAG_BIT];
  end

  generate
    if (HAS_WRAP) begin : g_wrap
      logic wrap_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wrap_q <= 1'b0;
        else if (wrap_ev) wrap_q <= 1'b1;
        else if (wr)      wrap_q <= wrap_q & wdata[WRAP_BIT];
      end
      assign wrap_flag = wrap_q;
    end else begin : g_nowrap
      assign wrap_flag = 1'b0;
    end
  endgenerate

  always_comb begin
    csr_rd = ctl_q;
    csr_rd[FLAG_BIT] = flag_q;
    if (HAS_WRAP) csr_rd[WRAP_BIT] = wrap_flag;
  end

  assign sel  = ctl_q[1:0];
  assign flag = flag_q;
  assign irq  = flag_q && ctl_q[IE_BIT];
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int CH_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [N_CH-1:0]  run_bits,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  localparam bit IS_W16   = (CNT_W == 16);
  localparam int FLAG_BIT = IS_W16 ? 7 : 15;
  localparam int IE_BIT   = IS_W16 ? 6 : 5;

  logic             run, count_en, cnt_apply, match_ev, wrap_ev, match_flag;
  logic             csr_wr, cnt_wr, cmp_wr;
  logic [1:0]       presc_sel;
  logic [15:0]      csr_rd;
  logic [CNT_W-1:0] cnt_q, cmp_q, csr_ext;

  assign run    = run_bits[CH_SEL];
  assign csr_wr = reg_wr && (reg_addr == IDX_CSR);
  assign cnt_wr = reg_wr && (reg_addr == IDX_CNT);
  assign cmp_wr = reg_wr && (reg_addr == IDX_CMP);

  cmt_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .slow_tick(slow_tick),
    .sel(presc_sel), .count_en(count_en)
  );

  cmt_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .count_en(count_en),
    .wr_cnt(cnt_wr), .wr_cmp(cmp_wr), .wdata(reg_wdata),
    .cnt(cnt_q), .cmp(cmp_q), .apply(cnt_apply),
    .match_ev(match_ev), .wrap_ev(wrap_ev)
  );

  cmt_ctrl_reg #(.FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT), .HAS_WRAP(!IS_W16)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(csr_wr), .wdata(reg_wdata[15:0]),
    .match_ev(match_ev), .wrap_ev(wrap_ev), .csr_rd(csr_rd),
    .sel(presc_sel), .flag(match_flag), .irq(irq)
  );

  always_comb begin
    csr_ext = '0;
    csr_ext[15:0] = csr_rd;
  end

  always_comb begin
    case (reg_addr)
      IDX_CSR: reg_rdata = csr_ext;
      IDX_CNT: reg_rdata = cnt_q;
      IDX_CMP: reg_rdata = cmp_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             count_en,
  input logic             apply,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             flag,
  input logic             irq,
  input logic             csr_wr
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !apply) |=> $stable(cnt)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !apply && cnt != cmp) |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1})); // R5

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !apply && cnt == cmp) |=> (cnt == '0 && flag)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !csr_wr) |=> flag); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R9
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .count_en(count_en), .apply(cnt_apply),
  .cnt(cnt_q), .cmp(cmp_q), .flag(match_flag), .irq(irq), .csr_wr(csr_wr)
);

// File: tb/cmt_channel_bench.sv
module cmt_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b1;
  logic [3:0]  run_bits = '0;
  logic [1:0]  addr = '0;
  logic        wr32 = 1'b0, wr16 = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata32;
  logic [15:0] rdata16;
  logic        irq32, irq16;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  cmt_channel #(.CNT_W(32), .N_CH(4), .CH_SEL(0)) u_cmt_channel (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .run_bits(run_bits),
    .reg_addr(addr), .reg_wr(wr32), .reg_wdata(wdata),
    .reg_rdata(rdata32), .irq(irq32)
  );

  cmt_channel #(.CNT_W(16), .N_CH(4), .CH_SEL(2)) u_cmt_channel_w16 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .run_bits(run_bits),
    .reg_addr(addr), .reg_wr(wr16), .reg_wdata(wdata[15:0]),
    .reg_rdata(rdata16), .irq(irq16)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit n16, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr32 = !n16; wr16 = n16;
    @(negedge clk);
    wr32 = 1'b0; wr16 = 1'b0;
  endtask

  task automatic rd(input bit n16, input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = n16 ? {16'h0, rdata16} : rdata32;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input bit n16, inout int k);
    while (!(n16 ? irq16 : irq32) && k < 4000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 2'd0, v); check("R1 csr32", v, 32'h0);
    rd(0, 2'd1, v); check("R1 cnt32", v, 32'h0);
    rd(0, 2'd2, v); check("R1 cmp32", v, 32'hFFFF_FFFF);
    rd(1, 2'd2, v); check("R1 cmp16", v, 32'h0000_FFFF);
    check("R1 irq", {30'h0, irq16, irq32}, 32'h0);
    rd(0, 2'd3, v); check("R2 idx3 reads zero", v, 32'h0);
  endtask

  task automatic t_period32();
    logic [31:0] v;
    int k = 0;
    wr(0, 2'd2, 32'd4);
    wr(0, 2'd0, 32'h1A4);
    rd(0, 2'd2, v); check("R2 cmp index", v, 32'd4);
    run_bits[0] = 1'b1;
    wait_irq(0, k);
    check("R5 period (4+1)*8", k, 40);
    rd(0, 2'd1, v); check("R5 cleared after match", v, 32'h0);
    rd(0, 2'd0, v); check("R6 flag bit15", v, 32'h81A4);
    idle(45);
    check("R6 flag sticky irq", {31'h0, irq32}, 32'h1);
    run_bits[0] = 1'b0;
  endtask

  task automatic t_clear_and_hold();
    logic [31:0] v, a, b;
    wr(0, 2'd0, 32'h01A4);
    check("R7 irq cleared", {31'h0, irq32}, 32'h0);
    rd(0, 2'd0, v); check("R7 flag cleared", v, 32'h01A4);
    wr(0, 2'd0, 32'h81A4);
    rd(0, 2'd0, v); check("R7 write one no effect", v, 32'h01A4);
    rd(0, 2'd1, a);
    run_bits[1] = 1'b1; run_bits[3] = 1'b1;
    idle(50);
    rd(0, 2'd1, b); check("R3 stopped holds, other bits ignored", b, a);
    run_bits = '0;
  endtask

  task automatic t_latency();
    logic [31:0] v, old;
    slow_tick = 1'b0;
    rd(0, 2'd1, old);
    wr(0, 2'd1, 32'd100);
    idle(3);
    rd(0, 2'd1, v); check("R10 no tick old value", v, old);
    slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    rd(0, 2'd1, v); check("R10 one tick old value", v, old);
    slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    rd(0, 2'd1, v); check("R10 two ticks new value", v, 32'd100);
    slow_tick = 1'b1;
  endtask

  task automatic t_presc_restart();
    logic [31:0] v;
    run_bits[0] = 1'b1; idle(5); run_bits[0] = 1'b0; idle(3);
    rd(0, 2'd1, v); check("R4 no count in partial period", v, 32'd100);
    run_bits[0] = 1'b1;
    idle(7);
    rd(0, 2'd1, v); check("R4 restart, 7 ticks", v, 32'd100);
    idle(1);
    rd(0, 2'd1, v); check("R4 restart, 8 ticks", v, 32'd101);
    run_bits[0] = 1'b0;
  endtask

  task automatic t_live_cmp();
    logic [31:0] v;
    int k = 0;
    wr(0, 2'd1, 32'd0); idle(3);
    wr(0, 2'd2, 32'hFFFF_FFFF);
    wr(0, 2'd0, 32'h01A4);
    run_bits[0] = 1'b1;
    idle(20); k = 20;
    wr(0, 2'd2, 32'd5); k = 22;
    wait_irq(0, k);
    check("R11 live compare match", k, 48);
    rd(0, 2'd1, v); check("R11 counter cleared", v, 32'h0);
    run_bits[0] = 1'b0;
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int k = 0;
    wr(0, 2'd0, 32'h01A4);
    wr(0, 2'd1, 32'hFFFF_FFFE); idle(3);
    run_bits[0] = 1'b1;
    idle(8);
    rd(0, 2'd0, v); check("R8 no wrap flag yet", v, 32'h01A4);
    idle(8);
    rd(0, 2'd1, v); check("R8 rolled to zero", v, 32'h0);
    rd(0, 2'd0, v); check("R8 wrap flag bit14", v, 32'h41A4);
    check("R9 wrap flag no irq", {31'h0, irq32}, 32'h0);
    run_bits[0] = 1'b0;
    wr(0, 2'd0, 32'h01A4);
    rd(0, 2'd0, v); check("R7 wrap flag cleared", v, 32'h01A4);
    run_bits[0] = 1'b1;
    wait_irq(0, k);
    check("R5 period from zero (5+1)*8", k, 48);
    run_bits[0] = 1'b0;
    wr(0, 2'd0, 32'h8184);
    check("R9 enable off drops irq", {31'h0, irq32}, 32'h0);
    rd(0, 2'd0, v); check("R9 flag kept", v, 32'h8184);
    wr(0, 2'd0, 32'h0);
    rd(0, 2'd0, v); check("R9 write zero", v, 32'h0);
  endtask

  task automatic t_w16();
    logic [31:0] v;
    int k = 0;
    wr(1, 2'd2, 32'd2);
    wr(1, 2'd0, 32'h43);
    run_bits[2] = 1'b1;
    wait_irq(1, k);
    check("R4 16-bit /512 period", k, 1536);
    rd(1, 2'd0, v); check("R6 16-bit flag bit7", v, 32'h00C3);
    run_bits[2] = 1'b0;
    wr(1, 2'd0, 32'h43);
    check("R9 16-bit irq clear", {31'h0, irq16}, 32'h0);
    rd(1, 2'd0, v); check("R7 16-bit flag cleared", v, 32'h0043);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_period32();
    t_clear_and_hold();
    t_latency();
    t_presc_restart();
    t_live_cmp();
    t_wrap();
    t_w16();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule